// File: doc/BRIEF.md
# I2C Slave Address-Phase Matcher

This block is the front end of an I2C or SMBus slave. It synchronises the SCL and SDA pins to the system clock and detects START, repeated START and STOP conditions. After a START it shifts in a seven-bit address and the read/write bit. It then compares that byte with each enabled address source in parallel. A match makes the block pull SDA low during the ninth clock as the acknowledge. It also reports which source matched and the direction of the transfer. An SMBus packet-error-checking byte counter sits next to the matcher and counts data bytes only when both SMBus mode and PEC are enabled.

Configuration uses a small write port with three registers. Select 0 holds the own address in bits [6:0]. Select 1 holds the control bits: bit 0 enables own-address matching, bit 1 enables general-call matching, bit 2 selects SMBus mode and bit 3 enables PEC. Select 2 loads the byte counter.

The state machine has seven states: `ST_IDLE`, `ST_ADDR`, `ST_ACK_WAIT`, `ST_ACK_LOW`, `ST_ACK_HIGH`, `ST_DATA` and `ST_SKIP`. A STOP in any state leads to `ST_IDLE`. Otherwise, a START in any state leads to `ST_ADDR`. The other transitions are:

- In `ST_ADDR`, the eighth SCL rise leads to `ST_ACK_WAIT` on a hit, or to `ST_SKIP` on a miss.
- `ST_ACK_WAIT` moves to `ST_ACK_LOW` on the next SCL fall.
- `ST_ACK_LOW` moves to `ST_ACK_HIGH` on the SCL rise.
- `ST_ACK_HIGH` moves to `ST_DATA` on the SCL fall.
- `ST_IDLE`, `ST_DATA` and `ST_SKIP` stay where they are until a START or a STOP.

Top module: `i2c_addr_match`

## Requirements
- R1: While reset is held and right after it is released, `sda_oe`, `match_pulse`, `match_own`, `match_gc`, `match_rw` and `pec_count` are all 0.
- R2: Address capture begins only after a START or a repeated START, where SDA falls while SCL is high. Bits are sampled on SCL rising edges, most significant address bit first, and the eighth bit is R/W (1 = read).
- R3: When the own address matches and own-address matching is enabled (control bit 0), `sda_oe` is 1 from the SCL fall after the eighth bit until the SCL fall after the ninth, and is 0 again after that.
- R4: While control bit 0 is clear, the own address is never acknowledged.
- R5: Address 0 with R/W = 0 is acknowledged as a general call only while control bit 1 is set. Address 0 with R/W = 1 is never acknowledged as a general call.
- R6: When both sources match the same byte, `match_own` is reported and `match_gc` stays 0.
- R7: Each acknowledged address raises `match_pulse` for exactly one clock, with `match_own`/`match_gc` naming the source and `match_rw` holding the received R/W bit. There is no pulse when no source matches.
- R8: If nothing matches, SDA stays released on the ninth clock. Later bytes are then ignored, with no acknowledge and no pulse, until the next START or repeated START.
- R9: A STOP, where SDA rises while SCL is high, returns the block to idle at any point and clears `match_own`, `match_gc`, `match_rw` and `sda_oe`. The match flags otherwise hold from the match until the next START or STOP.
- R10: With SMBus mode (bit 2) and PEC (bit 3) both set, each data byte after a matched address decrements `pec_count` by one at its ninth SCL rise. The counter stops at 0.
- R11: With SMBus mode or PEC clear, bus traffic leaves `pec_count` unchanged.
- R12: `pec_count` changes through software only by a write to select 2. Writes to selects 0 and 1 leave it unchanged.
- R13: A repeated START during the data phase starts a fresh address phase, which can be acknowledged again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL pin level |
| sda_i | input | 1 | SDA pin level (wired bus) |
| sda_oe | output | 1 | 1 = pull SDA low (acknowledge) |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 own address, 1 control, 2 byte counter |
| cfg_wdata | input | DATA_W | Register write data |
| match_pulse | output | 1 | One-cycle pulse on an acknowledged address |
| match_own | output | 1 | Own address matched (held) |
| match_gc | output | 1 | General call matched (held) |
| match_rw | output | 1 | Received R/W bit of the matched address |
| pec_count | output | CNT_W | SMBus PEC byte counter |

## Verification
A pin change reaches the condition detector two clocks later, after two synchroniser flops. Every result therefore appears on the third rising edge after the pin change: the match pulse and flags after the eighth SCL rise, `sda_oe` after the SCL falls, and `pec_count` after the ninth rise of a data byte. The bench holds each SCL phase for eight clocks and samples on falling clock edges, well past that three-edge delay. The driver task queues an expected `{own, gc, rw}` item for each address it expects to be acknowledged. A monitor pops one item for every `match_pulse` it sees, so a stray pulse or a missing pulse is reported.

// File: rtl/i2c_am_pkg.sv
package i2c_am_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK_WAIT,
        ST_ACK_LOW,
        ST_ACK_HIGH,
        ST_DATA,
        ST_SKIP
    } am_state_t;

    typedef struct packed {
        logic pec_en;
        logic smb_en;
        logic gc_en;
        logic own_en;
    } am_ctrl_t;

    localparam logic [1:0] SEL_OWN  = 2'd0;
    localparam logic [1:0] SEL_CTRL = 2'd1;
    localparam logic [1:0] SEL_CNT  = 2'd2;

endpackage

// File: rtl/i2c_am_cond.sv
// Pin synchroniser and bus condition detector.
module i2c_am_cond #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] scl_sh;
    logic [SYNC_STAGES-1:0] sda_sh;
    logic                   scl_q;
    logic                   sda_q;
    logic                   scl_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sh <= '1;
            sda_sh <= '1;
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
        end else begin
            scl_sh <= {scl_sh[SYNC_STAGES-2:0], scl_i};
            sda_sh <= {sda_sh[SYNC_STAGES-2:0], sda_i};
            scl_q  <= scl_sh[LAST];
            sda_q  <= sda_sh[LAST];
        end
    end

    assign scl_s     = scl_sh[LAST];
    assign sda_s     = sda_sh[LAST];
    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    assign start_evt = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_evt  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/i2c_am_cfg.sv
// Configuration registers and the SMBus PEC byte counter.
module i2c_am_cfg
    import i2c_am_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 8,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [1:0]        sel,
    input  logic [DATA_W-1:0] wdata,
    input  logic              byte_done,
    output logic [ADDR_W-1:0] own_addr,
    output am_ctrl_t          ctrl,
    output logic [CNT_W-1:0]  cnt,
    output logic              cnt_we,
    output logic              cnt_active
);
    localparam int CTRL_W = $bits(am_ctrl_t);

    assign cnt_we     = we && (sel == SEL_CNT);
    assign cnt_active = ctrl.smb_en && ctrl.pec_en;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            own_addr <= '0;
            ctrl     <= '0;
        end else if (we) begin
            if (sel == SEL_OWN)  own_addr <= wdata[ADDR_W-1:0];
            if (sel == SEL_CTRL) ctrl     <= am_ctrl_t'(wdata[CTRL_W-1:0]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (cnt_we) begin
            cnt <= wdata[CNT_W-1:0];
        end else if (byte_done && cnt_active && (cnt != '0)) begin
            cnt <= cnt - 1'b1;
        end
    end

endmodule

// File: rtl/i2c_am_match.sv
// Parallel comparison against all address sources.
module i2c_am_match #(
    parameter int ADDR_W = 7
) (
    input  logic [ADDR_W-1:0] cand_addr,
    input  logic              cand_rw,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              own_en,
    input  logic              gc_en,
    output logic              hit_own,
    output logic              hit_gc
);
    localparam logic [ADDR_W-1:0] GC_ADDR = '0;

    assign hit_own = own_en && (cand_addr == own_addr);
    assign hit_gc  = gc_en && (cand_addr == GC_ADDR) && !cand_rw;

endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match
    import i2c_am_pkg::*;
#(
    parameter int ADDR_W      = 7,
    parameter int DATA_W      = 8,
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic              match_pulse,
    output logic              match_own,
    output logic              match_gc,
    output logic              match_rw,
    output logic [CNT_W-1:0]  pec_count
);
    localparam int BYTE_W = ADDR_W + 1;
    localparam int FRAME  = BYTE_W + 1;
    localparam int BC_W   = $clog2(FRAME + 1);
    localparam logic [BC_W-1:0] LAST_ADDR_BIT = BC_W'(BYTE_W - 1);
    localparam logic [BC_W-1:0] LAST_DATA_BIT = BC_W'(FRAME - 1);

    logic sda_s, scl_rise, scl_fall, start_evt, stop_evt;

    i2c_am_cond #(.SYNC_STAGES(SYNC_STAGES)) u_cond (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_evt (start_evt),
        .stop_evt  (stop_evt)
    );

    am_state_t         state, state_nx;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] cand;
    logic [BC_W-1:0]   bitcnt;
    logic [ADDR_W-1:0] own_addr;
    am_ctrl_t          ctrl;
    logic              byte_done, cnt_we, cnt_active;
    logic              hit_own, hit_gc, hit_any, addr_last;

    i2c_am_cfg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .we         (cfg_we),
        .sel        (cfg_sel),
        .wdata      (cfg_wdata),
        .byte_done  (byte_done),
        .own_addr   (own_addr),
        .ctrl       (ctrl),
        .cnt        (pec_count),
        .cnt_we     (cnt_we),
        .cnt_active (cnt_active)
    );

    assign cand = {shreg[BYTE_W-2:0], sda_s};

    i2c_am_match #(.ADDR_W(ADDR_W)) u_match (
        .cand_addr (cand[BYTE_W-1:1]),
        .cand_rw   (cand[0]),
        .own_addr  (own_addr),
        .own_en    (ctrl.own_en),
        .gc_en     (ctrl.gc_en),
        .hit_own   (hit_own),
        .hit_gc    (hit_gc)
    );

    assign hit_any   = hit_own || hit_gc;
    assign addr_last = (state == ST_ADDR) && scl_rise && (bitcnt == LAST_ADDR_BIT);
    assign byte_done = (state == ST_DATA) && scl_rise && (bitcnt == LAST_DATA_BIT);

    // Next-state logic: STOP first, then START, then per-state progress.
    always_comb begin
        state_nx = state;
        if (stop_evt) begin
            state_nx = ST_IDLE;
        end else if (start_evt) begin
            state_nx = ST_ADDR;
        end else begin
            unique case (state)
                ST_IDLE:     state_nx = ST_IDLE;
                ST_ADDR:     if (addr_last) state_nx = hit_any ? ST_ACK_WAIT : ST_SKIP;
                ST_ACK_WAIT: if (scl_fall)  state_nx = ST_ACK_LOW;
                ST_ACK_LOW:  if (scl_rise)  state_nx = ST_ACK_HIGH;
                ST_ACK_HIGH: if (scl_fall)  state_nx = ST_DATA;
                ST_DATA:     state_nx = ST_DATA;
                ST_SKIP:     state_nx = ST_SKIP;
                default:     state_nx = ST_IDLE;
            endcase
        end
    end

    // State register with the bit counter and address shifter.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            shreg  <= '0;
            bitcnt <= '0;
        end else begin
            state <= state_nx;
            if (state_nx != state) begin
                bitcnt <= '0;
            end else if (scl_rise) begin
                if (state == ST_ADDR) begin
                    shreg  <= cand;
                    bitcnt <= bitcnt + 1'b1;
                end else if (state == ST_DATA) begin
                    bitcnt <= byte_done ? '0 : bitcnt + 1'b1;
                end
            end
        end
    end

    // Output register: match report and acknowledge drive.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            match_pulse <= 1'b0;
            match_own   <= 1'b0;
            match_gc    <= 1'b0;
            match_rw    <= 1'b0;
            sda_oe      <= 1'b0;
        end else begin
            match_pulse <= 1'b0;
            if (stop_evt || start_evt) begin
                match_own <= 1'b0;
                match_gc  <= 1'b0;
                match_rw  <= 1'b0;
            end else if (addr_last && hit_any) begin
                match_pulse <= 1'b1;
                match_own   <= hit_own;
                match_gc    <= hit_gc && !hit_own;
                match_rw    <= sda_s;
            end
            sda_oe <= (state_nx == ST_ACK_LOW) || (state_nx == ST_ACK_HIGH);
        end
    end

endmodule

// File: rtl/i2c_am_checker.sv
module i2c_am_checker #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sda_oe,
    input logic             match_pulse,
    input logic             match_own,
    input logic             match_gc,
    input logic             match_rw,
    input logic             stop_evt,
    input logic             cnt_active,
    input logic             cnt_we,
    input logic [CNT_W-1:0] pec_count
);
    AST_ACK_NEEDS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        sda_oe |-> (match_own || match_gc)); // R3

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        match_pulse |=> !match_pulse); // R7

    AST_SRC_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({match_own, match_gc})); // R6

    AST_GC_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        match_gc |-> !match_rw); // R5

    AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> (!match_own && !match_gc && !sda_oe && !match_pulse)); // R9

    AST_CNT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_active && !cnt_we) |=> $stable(pec_count)); // R11

endmodule

bind i2c_addr_match i2c_am_checker #(.CNT_W(CNT_W)) u_am_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .sda_oe      (sda_oe),
    .match_pulse (match_pulse),
    .match_own   (match_own),
    .match_gc    (match_gc),
    .match_rw    (match_rw),
    .stop_evt    (stop_evt),
    .cnt_active  (cnt_active),
    .cnt_we      (cnt_we),
    .pec_count   (pec_count)
);

// File: tb/i2c_addr_match_bench.sv
module i2c_addr_match_bench;
    localparam int Q = 8;

    typedef struct packed {
        logic own;
        logic gc;
        logic rw;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       cfg_we = 1'b0;
    logic [1:0] cfg_sel = 2'd0;
    logic [7:0] cfg_wdata = 8'd0;
    logic       sda_oe, match_pulse, match_own, match_gc, match_rw;
    logic [7:0] pec_count;
    logic       sda_bus;

    int   checks = 0;
    int   fails = 0;
    bit   done = 0;
    exp_t q[$];

    always #5 clk = ~clk;

    assign sda_bus = sda_m & ~sda_oe;

    i2c_addr_match u_i2c_addr_match (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_i       (scl_m),
        .sda_i       (sda_bus),
        .sda_oe      (sda_oe),
        .cfg_we      (cfg_we),
        .cfg_sel     (cfg_sel),
        .cfg_wdata   (cfg_wdata),
        .match_pulse (match_pulse),
        .match_own   (match_own),
        .match_gc    (match_gc),
        .match_rw    (match_rw),
        .pec_count   (pec_count)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cfg_write(input logic [1:0] sel, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        wq(2);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq(Q);
        scl_m = 1'b1; wq(Q);
        sda_m = 1'b0; wq(Q);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(Q);
        scl_m = 1'b1; wq(Q);
        sda_m = 1'b1; wq(Q);
    endtask

    task automatic send_bit(input logic b);
        sda_m = b;    wq(Q);
        scl_m = 1'b1; wq(Q);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic ack_clock(output bit got);
        sda_m = 1'b1; wq(Q);
        scl_m = 1'b1; wq(Q / 2);
        got = (sda_bus == 1'b0);
        wq(Q / 2);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic send_addr(input logic [6:0] a, input logic rw, input bit exp_ack,
                             input logic e_own, input logic e_gc, input string req);
        bit got;
        if (exp_ack) q.push_back('{own: e_own, gc: e_gc, rw: rw});
        for (int i = 6; i >= 0; i--) send_bit(a[i]);
        send_bit(rw);
        ack_clock(got);
        check(got == exp_ack, req, "ack on ninth clock", int'(got), int'(exp_ack));
        check(sda_oe == 1'b0, req, "sda released after ninth clock", int'(sda_oe), 0);
    endtask

    task automatic send_byte(input logic [7:0] d);
        bit got;
        for (int i = 7; i >= 0; i--) send_bit(d[i]);
        ack_clock(got);
    endtask

    // Monitor: pops one expected item per match pulse.
    always @(negedge clk) begin
        if (rst_n && match_pulse) begin
            if (q.size() == 0) begin
                check(1'b0, "R7", "unexpected match pulse", 1, 0);
            end else begin
                exp_t it;
                it = q.pop_front();
                check({match_own, match_gc, match_rw} == it, "R7", "match {own,gc,rw}",
                      int'({match_own, match_gc, match_rw}), int'(it));
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        wq(3);
        // R1: reset state
        check({sda_oe, match_pulse, match_own, match_gc, match_rw} == 5'b0, "R1",
              "outputs in reset", int'({sda_oe, match_pulse, match_own, match_gc, match_rw}), 0);
        rst_n = 1'b1;
        wq(3);
        check(pec_count == 8'd0 && sda_oe == 1'b0, "R1", "after reset",
              int'(pec_count), 0);

        // R2 R3: own address write and read
        cfg_write(2'd0, 8'h52);
        cfg_write(2'd1, 8'h01);
        bus_start();
        send_addr(7'h52, 1'b0, 1, 1, 0, "R3");
        check(match_own == 1'b1, "R9", "flag held after match", int'(match_own), 1);
        bus_stop();
        check({match_own, match_gc, match_rw} == 3'b0, "R9", "stop clears flags",
              int'({match_own, match_gc, match_rw}), 0);
        bus_start();
        send_addr(7'h52, 1'b1, 1, 1, 0, "R2");
        check(match_rw == 1'b1, "R7", "rw latched", int'(match_rw), 1);
        bus_stop();

        // R8: mismatch then bus ignored, R13 repeated start recovers
        bus_start();
        send_addr(7'h53, 1'b0, 0, 0, 0, "R8");
        send_addr(7'h52, 1'b0, 0, 0, 0, "R8");
        bus_start();
        send_addr(7'h52, 1'b0, 1, 1, 0, "R13");
        send_byte(8'h3C);
        bus_start();
        send_addr(7'h52, 1'b1, 1, 1, 0, "R13");
        bus_stop();

        // R9: stop in the middle of the address
        bus_start();
        for (int i = 0; i < 4; i++) send_bit(1'b1);
        bus_stop();
        check(sda_oe == 1'b0 && match_own == 1'b0, "R9", "mid-address stop idle",
              int'(match_own), 0);
        bus_start();
        send_addr(7'h52, 1'b0, 1, 1, 0, "R9");
        bus_stop();

        // R4 R5: sources disabled
        cfg_write(2'd1, 8'h00);
        bus_start();
        send_addr(7'h52, 1'b0, 0, 0, 0, "R4");
        bus_start();
        send_addr(7'h00, 1'b0, 0, 0, 0, "R5");
        bus_stop();

        // R5: general call only
        cfg_write(2'd1, 8'h02);
        bus_start();
        send_addr(7'h00, 1'b0, 1, 0, 1, "R5");
        check(match_gc == 1'b1 && match_own == 1'b0, "R5", "gc flag", int'(match_gc), 1);
        bus_stop();
        bus_start();
        send_addr(7'h00, 1'b1, 0, 0, 0, "R5");
        bus_stop();

        // R6: both sources match, own wins
        cfg_write(2'd0, 8'h00);
        cfg_write(2'd1, 8'h03);
        bus_start();
        send_addr(7'h00, 1'b0, 1, 1, 0, "R6");
        check(match_own == 1'b1 && match_gc == 1'b0, "R6", "own priority",
              int'({match_own, match_gc}), 2);
        bus_stop();

        // R10: counter active
        cfg_write(2'd0, 8'h52);
        cfg_write(2'd1, 8'h0D);
        cfg_write(2'd2, 8'd2);
        check(pec_count == 8'd2, "R12", "counter written", int'(pec_count), 2);
        bus_start();
        send_addr(7'h52, 1'b0, 1, 1, 0, "R10");
        send_byte(8'hA5);
        check(pec_count == 8'd1, "R10", "after byte 1", int'(pec_count), 1);
        send_byte(8'h5A);
        check(pec_count == 8'd0, "R10", "after byte 2", int'(pec_count), 0);
        send_byte(8'hFF);
        check(pec_count == 8'd0, "R10", "stops at zero", int'(pec_count), 0);
        bus_stop();

        // R11: plain I2C mode, then SMBus without PEC
        cfg_write(2'd1, 8'h01);
        cfg_write(2'd2, 8'd5);
        bus_start();
        send_addr(7'h52, 1'b0, 1, 1, 0, "R11");
        send_byte(8'h11);
        send_byte(8'h22);
        check(pec_count == 8'd5, "R11", "i2c mode frozen", int'(pec_count), 5);
        bus_stop();
        cfg_write(2'd1, 8'h05);
        bus_start();
        send_addr(7'h52, 1'b0, 1, 1, 0, "R11");
        send_byte(8'h33);
        check(pec_count == 8'd5, "R11", "smbus no pec frozen", int'(pec_count), 5);
        bus_stop();

        // R12: other register writes leave the counter
        cfg_write(2'd0, 8'hFF);
        cfg_write(2'd1, 8'h0F);
        check(pec_count == 8'd5, "R12", "other writes", int'(pec_count), 5);
        cfg_write(2'd2, 8'd9);
        check(pec_count == 8'd9, "R12", "counter write", int'(pec_count), 9);

        wq(10);
        check(q.size() == 0, "R7", "pending expected pulses", q.size(), 0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule